// File: doc/BRIEF.md
# Write-Only Bank Register with Nametable Mirroring Select

This block sits on the cartridge side of an 8-bit console CPU bus. It watches for CPU write cycles into a sparsely decoded address region and, when one completes, stores the data bus into an 8-bit register. Only five bus conditions take part in the decode, so the register answers at every address that matches them. The lower seven register bits drive bank-select lines toward the memory arrays. The top bit picks which picture-bus address bit is routed onto the nametable address line, and so sets the mirroring arrangement.

Everything runs in a single system clock domain. The CPU clock phase M2 and the CPU bus signals pass through a synchronizer of parameterised depth. A write is committed on the detected falling edge of M2, using the data seen in the last sampled cycle of the high phase, provided the decode held in that cycle. The picture-bus path is purely combinational, because nametable addressing has to follow the picture bus without clock latency. A synchronous clear stands in for the console reset and empties the register.

Top module: `cart_bank_latch`

## Requirements
- R1: A write is committed only if, in the last synchronized sample of the M2 high phase, all of these hold: `rom_sel_n`=1, `cpu_a14`=1, `cpu_a8`=1, `cpu_a13`=0 and `cpu_rw_n`=0.
- R2: The register keeps its old value while M2 stays high. It takes the data present at the end of the high phase, so a data change partway through the high phase means the later value wins.
- R3: The register changes only when a write is committed. Between commits it holds its value.
- R4: A cycle with `cpu_rw_n`=1 (read) that otherwise matches the decode never changes the register.
- R5: A cycle that fails the decode on any single line never changes the register. The failing lines are `rom_sel_n`=0, `cpu_a14`=0, `cpu_a8`=0 or `cpu_a13`=1.
- R6: While `clr` is high, the register is all zeros on the next clock, so `bank_sel`=0 and mirroring select bit 7=0.
- R7: `bank_sel[6:0]` equals register bits 6..0 of the last committed write.
- R8: When register bit 7 is 1, `nt_addr` equals `ppu_a11`, giving a vertical arrangement (horizontal mirroring).
- R9: When register bit 7 is 0, `nt_addr` equals `ppu_a10`, giving a horizontal arrangement (vertical mirroring).
- R10: A committed value appears on the outputs no later than SYNC_STAGES+2 clocks after M2 falls, and not before the second clock edge after M2 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Synchronous clear, active high (console reset) |
| rom_sel_n | input | 1 | ROM-select strobe, active low |
| m2 | input | 1 | CPU clock phase |
| cpu_rw_n | input | 1 | CPU read (1) / write (0) |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_a8 | input | 1 | CPU address bit 8 |
| cpu_d | input | DATA_W | CPU data bus |
| ppu_a10 | input | 1 | Picture-bus address bit 10 |
| ppu_a11 | input | 1 | Picture-bus address bit 11 |
| bank_sel | output | DATA_W-1 | Bank-select lines, register bits 6..0 |
| nt_addr | output | 1 | Nametable address line |

## Verification
The bench aims at the end of the M2 high phase. It changes the data bus partway through the high phase and checks that the register still shows its old value one clock after M2 falls. A design that captured on the rising edge or at the first qualifying sample would show the early data, or show it too soon. Reads and single-line decode misses are aimed at writes that trigger on a partial match or ignore the R/W line; such a design would overwrite the bank lines. Each mirroring mode is swept over all four PA11/PA10 combinations, which exposes a swapped or inverted select, and a clear after a nonzero write exposes a register that does not reset.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    localparam int CBL_DATA_W = 8;

    // One sample of the CPU bus as seen by the cartridge
    typedef struct packed {
        logic                  m2;
        logic                  rom_sel_n;
        logic                  rw_n;
        logic                  a14;
        logic                  a13;
        logic                  a8;
        logic [CBL_DATA_W-1:0] data;
    } cbl_bus_t;

    localparam int CBL_BUS_W = $bits(cbl_bus_t);

    // Decoder state
    typedef struct packed {
        logic                  m2_prev;
        logic                  pending;
        logic [CBL_DATA_W-1:0] hold;
    } cbl_dec_state_t;

endpackage

// File: rtl/cbl_sync.sv
module cbl_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] pipe_d;
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_comb begin
        pipe_d[0] = din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_comb begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (clr) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/cbl_decode.sv
module cbl_decode
    import cbl_pkg::*;
(
    input  logic                  clk,
    input  logic                  clr,
    input  cbl_bus_t              bus_s,
    output logic                  commit,
    output logic [CBL_DATA_W-1:0] commit_data
);

    cbl_dec_state_t st_d, st_q;
    logic           hit;
    logic           m2_fall;

    always_comb begin
        // register select: strobe inactive, M2 high, A14=1, A8=1, A13=0, write
        hit = bus_s.m2 && bus_s.rom_sel_n && bus_s.a14 && bus_s.a8
              && !bus_s.a13 && !bus_s.rw_n;
        m2_fall = st_q.m2_prev && !bus_s.m2;

        st_d         = st_q;
        st_d.m2_prev = bus_s.m2;
        if (bus_s.m2) begin
            st_d.pending = hit;
            if (hit) st_d.hold = bus_s.data;
        end else begin
            st_d.pending = 1'b0;
        end

        commit      = m2_fall && st_q.pending;
        commit_data = st_q.hold;
    end

    always_ff @(posedge clk) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    // R1: a commit follows a cycle in which the full decode matched
    p_commit_after_hit_r1: assert property (@(posedge clk) disable iff (clr)
        commit |-> $past(hit));

    // R2: commits happen only at the end of the M2 high phase
    p_commit_on_fall_r2: assert property (@(posedge clk) disable iff (clr)
        commit |-> ($past(bus_s.m2) && !bus_s.m2));

    // R4: a read never commits
    p_no_read_commit_r4: assert property (@(posedge clk) disable iff (clr)
        commit |-> !$past(bus_s.rw_n));

endmodule

// File: rtl/cbl_mirror_mux.sv
module cbl_mirror_mux (
    input  logic sel,
    input  logic pa10,
    input  logic pa11,
    output logic nt
);

    always_comb begin
        nt = sel ? pa11 : pa10;
    end

endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
    import cbl_pkg::*;
#(
    parameter int DATA_W      = CBL_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              rom_sel_n,
    input  logic              m2,
    input  logic              cpu_rw_n,
    input  logic              cpu_a14,
    input  logic              cpu_a13,
    input  logic              cpu_a8,
    input  logic [DATA_W-1:0] cpu_d,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    output logic [DATA_W-2:0] bank_sel,
    output logic              nt_addr
);

    localparam int MIR_BIT = DATA_W - 1;

    cbl_bus_t                bus_raw;
    cbl_bus_t                bus_s;
    logic [CBL_BUS_W-1:0]    bus_s_vec;
    logic                    commit;
    logic [CBL_DATA_W-1:0]   commit_data;
    logic [DATA_W-1:0]       reg_d, reg_q;

    always_comb begin
        bus_raw.m2        = m2;
        bus_raw.rom_sel_n = rom_sel_n;
        bus_raw.rw_n      = cpu_rw_n;
        bus_raw.a14       = cpu_a14;
        bus_raw.a13       = cpu_a13;
        bus_raw.a8        = cpu_a8;
        bus_raw.data      = CBL_DATA_W'(cpu_d);
    end

    cbl_sync #(
        .W      (CBL_BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .clr  (clr),
        .din  (bus_raw),
        .dout (bus_s_vec)
    );

    assign bus_s = cbl_bus_t'(bus_s_vec);

    cbl_decode u_decode (
        .clk         (clk),
        .clr         (clr),
        .bus_s       (bus_s),
        .commit      (commit),
        .commit_data (commit_data)
    );

    always_comb begin
        reg_d = reg_q;
        if (commit) reg_d = DATA_W'(commit_data);
    end

    always_ff @(posedge clk) begin
        if (clr) reg_q <= '0;
        else     reg_q <= reg_d;
    end

    cbl_mirror_mux u_mux (
        .sel  (reg_q[MIR_BIT]),
        .pa10 (ppu_a10),
        .pa11 (ppu_a11),
        .nt   (nt_addr)
    );

    assign bank_sel = reg_q[MIR_BIT-1:0];

    // R3: without a commit the register holds
    p_hold_without_commit_r3: assert property (@(posedge clk) disable iff (clr)
        !commit |=> $stable(reg_q));

    // R6: clear empties the register
    p_clear_zero_r6: assert property (@(posedge clk)
        clr |=> (reg_q == '0));

    // R8: select 1 routes PA11
    p_nt_a11_r8: assert property (@(posedge clk) disable iff (clr)
        reg_q[MIR_BIT] |-> (nt_addr == ppu_a11));

    // R9: select 0 routes PA10
    p_nt_a10_r9: assert property (@(posedge clk) disable iff (clr)
        !reg_q[MIR_BIT] |-> (nt_addr == ppu_a10));

endmodule

// File: tb/cart_bank_latch_tb.sv
`timescale 1ns/1ps
module cart_bank_latch_tb;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic          rom_sel_n = 1'b0;
    logic          m2 = 1'b0;
    logic          cpu_rw_n = 1'b1;
    logic          cpu_a14 = 1'b0;
    logic          cpu_a13 = 1'b0;
    logic          cpu_a8 = 1'b0;
    logic [DW-1:0] cpu_d = '0;
    logic          ppu_a10 = 1'b0;
    logic          ppu_a11 = 1'b0;
    logic [DW-2:0] bank_sel;
    logic          nt_addr;

    int            n_checks = 0;
    int            n_fail   = 0;
    logic [DW-1:0] model    = '0;

    always #2.5 clk = ~clk;

    cart_bank_latch #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .clr(clr), .rom_sel_n(rom_sel_n), .m2(m2),
        .cpu_rw_n(cpu_rw_n), .cpu_a14(cpu_a14), .cpu_a13(cpu_a13),
        .cpu_a8(cpu_a8), .cpu_d(cpu_d), .ppu_a10(ppu_a10),
        .ppu_a11(ppu_a11), .bank_sel(bank_sel), .nt_addr(nt_addr)
    );

    function automatic logic decode_hit(logic rs, logic rw, logic a14, logic a13, logic a8);
        return rs && a14 && a8 && !a13 && !rw;
    endfunction

    function automatic logic exp_nt(logic [DW-1:0] r, logic p10, logic p11);
        return r[DW-1] ? p11 : p10;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one full CPU cycle; data may change partway through the high phase
    task automatic bus_cycle(logic rs, logic rw, logic a14, logic a13, logic a8,
                             logic [DW-1:0] d_early, logic [DW-1:0] d_late);
        @(negedge clk);
        rom_sel_n = rs; cpu_rw_n = rw; cpu_a14 = a14; cpu_a13 = a13;
        cpu_a8 = a8; cpu_d = d_early; m2 = 1'b0;
        wait_neg(3);
        m2 = 1'b1;
        wait_neg(4);
        cpu_d = d_late;
        wait_neg(4);
        chk("R2 hold during high phase", 32'(bank_sel), 32'(model[DW-2:0]));
        m2 = 1'b0;
        wait_neg(1);
        chk("R10 no early update", 32'(bank_sel), 32'(model[DW-2:0]));
        if (decode_hit(rs, rw, a14, a13, a8)) model = d_late;
        wait_neg(3);
        chk("R10/R7 bank after cycle", 32'(bank_sel), 32'(model[DW-2:0]));
        rom_sel_n = 1'b0; cpu_rw_n = 1'b1;
        wait_neg(2);
    endtask

    task automatic sweep_nt(string req);
        for (int k = 0; k < 4; k++) begin
            ppu_a10 = k[0]; ppu_a11 = k[1];
            #1;
            chk(req, 32'(nt_addr), 32'(exp_nt(model, k[0], k[1])));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1357_2468));
        wait_neg(4);
        clr = 1'b0;
        wait_neg(1);
        chk("R6 reset bank", 32'(bank_sel), 32'h0);
        sweep_nt("R9 reset mode");

        // R1: full match write, select 0
        bus_cycle(1, 0, 1, 0, 1, 8'h11, 8'h2A);
        chk("R1 write lands", 32'(bank_sel), 32'h2A);
        sweep_nt("R9 select 0");

        // R1/R8: write with bit 7 set
        bus_cycle(1, 0, 1, 0, 1, 8'h00, 8'hC5);
        chk("R7 low bits", 32'(bank_sel), 32'h45);
        sweep_nt("R8 select 1");

        // R4: read does not change
        bus_cycle(1, 1, 1, 0, 1, 8'h3C, 8'h3C);
        chk("R4 read ignored", 32'(bank_sel), 32'h45);
        sweep_nt("R4 mode kept after read");

        // R5: each single-line miss
        bus_cycle(0, 0, 1, 0, 1, 8'h01, 8'h01);
        chk("R5 rom_sel_n low", 32'(bank_sel), 32'h45);
        bus_cycle(1, 0, 0, 0, 1, 8'h02, 8'h02);
        chk("R5 a14 low", 32'(bank_sel), 32'h45);
        bus_cycle(1, 0, 1, 1, 1, 8'h03, 8'h03);
        chk("R5 a13 high", 32'(bank_sel), 32'h45);
        bus_cycle(1, 0, 1, 0, 0, 8'h04, 8'h04);
        chk("R5 a8 low", 32'(bank_sel), 32'h45);
        sweep_nt("R3 mode held after misses");

        // R2: late data wins, back to select 0
        bus_cycle(1, 0, 1, 0, 1, 8'hFF, 8'h7E);
        chk("R2 late data", 32'(bank_sel), 32'h7E);
        sweep_nt("R9 back to select 0");

        // constrained random mix
        for (int it = 0; it < 60; it++) begin
            logic [DW-1:0] de, dl;
            logic rs, rw, a14, a13, a8;
            de = DW'($urandom); dl = DW'($urandom);
            if ($urandom % 2 == 0) begin
                rs = 1; rw = 0; a14 = 1; a13 = 0; a8 = 1;
            end else begin
                rs = 1'($urandom); rw = 1'($urandom); a14 = 1'($urandom);
                a13 = 1'($urandom); a8 = 1'($urandom);
            end
            bus_cycle(rs, rw, a14, a13, a8, de, dl);
            sweep_nt(model[DW-1] ? "R8 random" : "R9 random");
        end

        // R6: clear after nonzero write
        bus_cycle(1, 0, 1, 0, 1, 8'h00, 8'hA9);
        @(negedge clk);
        clr = 1'b1;
        wait_neg(2);
        clr = 1'b0;
        model = '0;
        wait_neg(1);
        chk("R6 clear bank", 32'(bank_sel), 32'h0);
        sweep_nt("R6 clear mode");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule